// File: doc/BRIEF.md
# Interrupting 32-Pin GPIO Controller

This block is a general-purpose I/O controller for 32 pins, reached through a small register bus with a 32-byte window. Software sets output levels and per-pin output enables. It reads back the live pin levels after a two-flop synchronizer. It chooses for every pin which condition raises an interrupt: low level, high level, rising edge or falling edge. A per-pin override makes a pin trigger on both edges.

Detected conditions set sticky status bits, which software clears by writing ones. A single interrupt line is the OR of the status bits that are enabled by the mask register. The bus is a single-cycle interface: a write takes effect at the clock edge on which it is presented, and read data is returned combinationally for the addressed word.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, `pad_out` and `pad_oe` are zero and `irq` is low.
- R2: The word at offset 0x00 drives `pad_out` and the word at offset 0x04 drives `pad_oe`, where a 1 bit makes that pin an output. Both read back what was written.
- R3: Offset 0x08 returns the pin levels as they stood two clock edges earlier. Writes to it change no register.
- R4: Trigger mode 0 sets a pin's status bit on every cycle while the synchronized pin is low, and mode 1 does so while it is high, so a clear does not hold while the level persists.
- R5: Mode 2 sets the status bit once on a synchronized 0-to-1 change, and mode 3 sets it once on a 1-to-0 change. The opposite change has no effect.
- R6: The word at offset 0x0C holds the 2-bit modes for pins 0 to 15 and the word at 0x10 holds pins 16 to 31. Pin n uses bits [2n+1:2n] of its word, counted from the first pin of that word.
- R7: When a pin's bit at offset 0x1C is 1, the pin sets its status on both edges and its configured mode is ignored.
- R8: Writing to the status word at offset 0x18 clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R9: A status bit whose trigger condition occurs in the same cycle as a clear of that bit stays set.
- R10: `irq` is high exactly when some status bit is set together with its bit in the mask word at offset 0x14. Status bits latch whether or not they are masked.
- R11: Bus accesses at byte addresses that are not multiples of four write nothing and read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pad_in | input | 32 | Raw pin levels |
| pad_out | output | 32 | Output levels |
| pad_oe | output | 32 | Output enables |
| irq | output | 1 | Combined masked interrupt |

## Verification
Software clearing a status bit and the hardware setting that same bit can fall in the same clock cycle.

The bench provokes this in two ways. In the first, a pin in high-level mode is held high while the clear is written. In the second, a pin in rising-edge mode is driven up exactly three edges before the clear's commit edge, so its detection lands on that edge.

In both cases the bench reads the status word right after the write. It expects the contested bit to remain 1 while every other written bit drops to 0.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int GPIO_W   = 32;
    localparam int ADDR_W   = 5;
    localparam int MODE_W   = 2;
    localparam int PINS_PER_CFG = GPIO_W / MODE_W;

    // word index = byte address [4:2]
    localparam logic [2:0] W_DATA   = 3'd0;
    localparam logic [2:0] W_DIR    = 3'd1;
    localparam logic [2:0] W_LEVELS = 3'd2;
    localparam logic [2:0] W_CFG_LO = 3'd3;
    localparam logic [2:0] W_CFG_HI = 3'd4;
    localparam logic [2:0] W_MASK   = 3'd5;
    localparam logic [2:0] W_STATUS = 3'd6;
    localparam logic [2:0] W_ANYEDG = 3'd7;

    typedef enum logic [MODE_W-1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_HIGH = 2'd1,
        TRIG_RISE = 2'd2,
        TRIG_FALL = 2'd3
    } trig_mode_e;

    typedef struct packed {
        logic [GPIO_W-1:0] data;
        logic [GPIO_W-1:0] dir;
        logic [GPIO_W-1:0] cfg_lo;
        logic [GPIO_W-1:0] cfg_hi;
        logic [GPIO_W-1:0] mask;
        logic [GPIO_W-1:0] status;
        logic [GPIO_W-1:0] anyedge;
    } gpio_regs_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] sync;
        logic [W-1:0] prev;
        logic         live;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = raw_i;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
        st_d.live = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.sync;
    assign prev_o = st_q.prev;

    AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.live |=> sync_o == $past(raw_i, 2)) else $error("sync latency");   // R3
endmodule

// File: rtl/gpio_trig.sv
module gpio_trig
    import gpio_irq_pkg::*;
#(
    parameter int W = GPIO_W
) (
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] cfg_lo_i,
    input  logic [W-1:0] cfg_hi_i,
    input  logic [W-1:0] anyedge_i,
    output logic [W-1:0] evt_o
);
    localparam int HALF = W / MODE_W;

    for (genvar p = 0; p < W; p++) begin : g_pin
        trig_mode_e mode;
        logic       rise, fall;

        if (p < HALF) begin : g_lo
            assign mode = trig_mode_e'(cfg_lo_i[MODE_W*p +: MODE_W]);
        end else begin : g_hi
            assign mode = trig_mode_e'(cfg_hi_i[MODE_W*(p-HALF) +: MODE_W]);
        end

        assign rise = sync_i[p] & ~prev_i[p];
        assign fall = ~sync_i[p] & prev_i[p];

        always_comb begin
            if (anyedge_i[p]) begin
                evt_o[p] = rise | fall;
            end else begin
                unique case (mode)
                    TRIG_LOW:  evt_o[p] = ~sync_i[p];
                    TRIG_HIGH: evt_o[p] = sync_i[p];
                    TRIG_RISE: evt_o[p] = rise;
                    TRIG_FALL: evt_o[p] = fall;
                    default:   evt_o[p] = 1'b0;
                endcase
            end
        end

        always_comb begin
            if (anyedge_i[p] === 1'b1 && evt_o[p] === 1'b1)
                AST_ANYEDGE_NEEDS_CHANGE: assert (sync_i[p] != prev_i[p]);   // R7
        end
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [GPIO_W-1:0] bus_wdata,
    output logic [GPIO_W-1:0] bus_rdata,
    input  logic [GPIO_W-1:0] pad_in,
    output logic [GPIO_W-1:0] pad_out,
    output logic [GPIO_W-1:0] pad_oe,
    output logic              irq
);
    gpio_regs_t        regs_d, regs_q;
    logic [GPIO_W-1:0] levels, levels_prev, evt;
    logic              aligned, wr_hit;
    logic [2:0]        word;
    logic [GPIO_W-1:0] clr_mask;

    gpio_sync #(.W(GPIO_W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pad_in),
        .sync_o (levels),
        .prev_o (levels_prev)
    );

    gpio_trig #(.W(GPIO_W)) u_trig (
        .sync_i    (levels),
        .prev_i    (levels_prev),
        .cfg_lo_i  (regs_q.cfg_lo),
        .cfg_hi_i  (regs_q.cfg_hi),
        .anyedge_i (regs_q.anyedge),
        .evt_o     (evt)
    );

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign word    = bus_addr[ADDR_W-1:2];
    assign wr_hit  = bus_sel & bus_wr & aligned;

    always_comb begin
        regs_d   = regs_q;
        clr_mask = '0;
        if (wr_hit) begin
            unique case (word)
                W_DATA:   regs_d.data    = bus_wdata;
                W_DIR:    regs_d.dir     = bus_wdata;
                W_CFG_LO: regs_d.cfg_lo  = bus_wdata;
                W_CFG_HI: regs_d.cfg_hi  = bus_wdata;
                W_MASK:   regs_d.mask    = bus_wdata;
                W_STATUS: clr_mask       = bus_wdata;
                W_ANYEDG: regs_d.anyedge = bus_wdata;
                default:  ;
            endcase
        end
        regs_d.status = (regs_q.status & ~clr_mask) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr && aligned) begin
            unique case (word)
                W_DATA:   bus_rdata = regs_q.data;
                W_DIR:    bus_rdata = regs_q.dir;
                W_LEVELS: bus_rdata = levels;
                W_CFG_LO: bus_rdata = regs_q.cfg_lo;
                W_CFG_HI: bus_rdata = regs_q.cfg_hi;
                W_MASK:   bus_rdata = regs_q.mask;
                W_STATUS: bus_rdata = regs_q.status;
                W_ANYEDG: bus_rdata = regs_q.anyedge;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign pad_out = regs_q.data;
    assign pad_oe  = regs_q.dir;
    assign irq     = |(regs_q.status & regs_q.mask);

    AST_OE_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 5'h04) |=> pad_oe == $past(bus_wdata));   // R2
    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> (regs_q.status & $past(evt)) == $past(evt));   // R9
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 5'h18)
        |=> (regs_q.status & $past(bus_wdata) & ~$past(evt)) == '0);   // R8
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.mask == '0) |-> !irq);   // R10
    AST_MISALIGNED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr[1:0] != 2'b00)
        |=> $stable(pad_out) && $stable(pad_oe));   // R11
endmodule

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;

    localparam logic [31:0] ALL_RISE = 32'hAAAA_AAAA;

    always #10 clk = ~clk;

    gpio_irq_ctrl i_gpio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic drive_pads(input logic [31:0] v);
        @(negedge clk);
        pad_in = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all();
        bus_write(5'h18, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] r;
        @(negedge clk);
        bus_read(5'h00, r); check("R1 data", r, 32'h0);
        bus_read(5'h04, r); check("R1 dir", r, 32'h0);
        bus_read(5'h14, r); check("R1 mask", r, 32'h0);
        bus_read(5'h0C, r); check("R1 cfg_lo", r, 32'h0);
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        repeat (3) @(negedge clk);
        bus_read(5'h18, r); check("R4 low-level all pins", r, 32'hFFFF_FFFF);
    endtask

    task automatic t_setup();
        logic [31:0] r;
        bus_write(5'h0C, ALL_RISE);
        bus_write(5'h10, ALL_RISE);
        clear_all();
        bus_read(5'h18, r); check("R8 cleared", r, 32'h0);
    endtask

    task automatic t_outputs();
        logic [31:0] r;
        bus_write(5'h00, 32'hA5A5_0F0F);
        bus_write(5'h04, 32'hFFFF_0000);
        check("R2 pad_out", pad_out, 32'hA5A5_0F0F);
        check("R2 pad_oe", pad_oe, 32'hFFFF_0000);
        bus_read(5'h04, r); check("R2 dir readback", r, 32'hFFFF_0000);
    endtask

    task automatic t_levels();
        logic [31:0] r;
        @(negedge clk);
        pad_in = 32'h1234_5678;
        @(posedge clk); @(negedge clk);
        bus_read(5'h08, r); check("R3 one edge not yet", r, 32'h0);
        @(posedge clk); @(negedge clk);
        bus_read(5'h08, r); check("R3 two edges", r, 32'h1234_5678);
        bus_write(5'h08, 32'hFFFF_FFFF);
        bus_read(5'h00, r); check("R3 write ignored data", r, 32'hA5A5_0F0F);
        bus_read(5'h04, r); check("R3 write ignored dir", r, 32'hFFFF_0000);
        bus_read(5'h08, r); check("R3 still pads", r, 32'h1234_5678);
        drive_pads(32'h0);
        clear_all();
    endtask

    task automatic t_edges();
        logic [31:0] r;
        drive_pads(32'h0000_0008);
        bus_read(5'h18, r); check("R5 rising pin3", r, 32'h0000_0008);
        bus_write(5'h18, 32'h0);
        bus_read(5'h18, r); check("R8 zero write keeps", r, 32'h0000_0008);
        bus_write(5'h18, 32'h0000_0008);
        bus_read(5'h18, r); check("R8 one write clears", r, 32'h0);
        drive_pads(32'h0);
        bus_read(5'h18, r); check("R5 falling ignored in rise mode", r, 32'h0);
        bus_write(5'h0C, 32'hAAAA_AEAA);
        drive_pads(32'h0000_0020);
        bus_read(5'h18, r); check("R5 rise ignored in fall mode", r, 32'h0);
        drive_pads(32'h0);
        bus_read(5'h18, r); check("R5 falling pin5", r, 32'h0000_0020);
        bus_write(5'h0C, ALL_RISE);
        clear_all();
    endtask

    task automatic t_level_high();
        logic [31:0] r;
        bus_write(5'h10, 32'hAAAA_A9AA);
        drive_pads(32'h0010_0010);
        clear_all();
        bus_read(5'h18, r); check("R6 pin20 level high, pin4 edge only", r, 32'h0010_0000);
        bus_read(5'h18, r); check("R9 level set same cycle as clear", r, 32'h0010_0000);
        drive_pads(32'h0);
        clear_all();
        bus_read(5'h18, r); check("R4 level gone stays clear", r, 32'h0);
        bus_write(5'h10, ALL_RISE);
    endtask

    task automatic t_anyedge();
        logic [31:0] r;
        bus_write(5'h1C, 32'h0000_0080);
        drive_pads(32'h0000_0080);
        bus_read(5'h18, r); check("R7 rise with anyedge", r, 32'h0000_0080);
        clear_all();
        drive_pads(32'h0);
        bus_read(5'h18, r); check("R7 fall with anyedge in rise mode", r, 32'h0000_0080);
        clear_all();
        bus_write(5'h1C, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] r;
        drive_pads(32'h0000_0002);
        check("R10 unmasked quiet", {31'h0, irq}, 32'h0);
        bus_read(5'h18, r); check("R10 latched while masked", r, 32'h0000_0002);
        bus_write(5'h14, 32'h0000_0004);
        check("R10 other mask bit", {31'h0, irq}, 32'h0);
        bus_write(5'h14, 32'h0000_0002);
        check("R10 irq raised", {31'h0, irq}, 32'h1);
        clear_all();
        check("R10 irq drops on clear", {31'h0, irq}, 32'h0);
        bus_write(5'h14, 32'h0);
        drive_pads(32'h0);
    endtask

    task automatic t_race_edge();
        logic [31:0] r;
        drive_pads(32'h0000_0001);
        @(negedge clk);
        pad_in = 32'h0000_0201;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h18; bus_wdata = 32'hFFFF_FFFF;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        bus_read(5'h18, r); check("R9 edge vs clear", r, 32'h0000_0200);
        drive_pads(32'h0);
        clear_all();
    endtask

    task automatic t_misaligned();
        logic [31:0] r;
        bus_write(5'h01, 32'hDEAD_BEEF);
        bus_write(5'h06, 32'hDEAD_BEEF);
        bus_read(5'h00, r); check("R11 data untouched", r, 32'hA5A5_0F0F);
        bus_read(5'h04, r); check("R11 dir untouched", r, 32'hFFFF_0000);
        bus_read(5'h06, r); check("R11 misaligned read", r, 32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_setup();
        t_outputs();
        t_levels();
        t_edges();
        t_level_high();
        t_anyedge();
        t_irq();
        t_race_edge();
        t_misaligned();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule